// File: doc/BRIEF.md
# EDID Base Block Rewriter

This block sits in the display-identification path of a converter that bridges an analog video link and a digital one. A 128-byte base identification block streams in one byte per transfer over a valid/ready handshake. The same 128 bytes stream out, patched so that a source on the other side sees a sink it can drive. A direction input picks the patch set. In analog mode the sink is presented as an analog-input display with no extension blocks. In digital mode it is presented as a digital-input display with exactly one extension block to follow.

Each of the four 18-byte descriptor slots is inspected. A timing descriptor whose pixel clock exceeds the converter's limit is swapped wholesale for a safe 640x480 progressive 60 Hz timing. The trailing checksum byte is regenerated from the bytes actually emitted. While bytes pass through, the block also checks the 8-byte fixed header and the integrity of the incoming checksum, and reports both with the end of the block.

An output byte is released only once the following input byte has been accepted, because a slot's pixel clock spans two bytes. Output back-pressure stalls the input side.

Top module: `edid_rewriter`

## Requirements
- R1: Every block of 128 accepted input bytes yields exactly 128 output bytes, in order. Every byte other than 0x14, 0x7E, 0x7F and the bytes of a replaced descriptor slot is copied unchanged.
- R2: Output byte 0x14 carries the input byte with bit 7 forced to 1 in digital mode (mode_dig=1) and to 0 in analog mode. Bits 6:0 are kept.
- R3: Output byte 0x7E is 0x01 in digital mode and 0x00 in analog mode, whatever the input held.
- R4: Descriptor slots start at 0x36, 0x48, 0x5A and 0x6C and are 18 bytes long. The pixel clock is the little-endian 16-bit value in the first two bytes of a slot, in 10 kHz units. A slot whose pixel clock is greater than MAX_PCLK (default 16500) is output as the 18 bytes D6 09 80 A0 20 E0 2D 10 10 60 A2 00 00 00 00 00 00 18.
- R5: A slot whose pixel clock is zero (display descriptor) or not above MAX_PCLK passes unchanged, including a value exactly equal to MAX_PCLK.
- R6: Output byte 0x7F is the value that makes the 8-bit sum of all 128 output bytes zero.
- R7: header_err is 1 for a block whose input bytes 0x00..0x07 differ anywhere from 00 FF FF FF FF FF FF 00, and 0 otherwise.
- R8: in_csum_err is 1 for a block whose 128 input bytes do not sum to zero modulo 256, and 0 otherwise.
- R9: blk_done is high only while the final output byte (0x7F) is presented, once per block. header_err and in_csum_err change only when the last input byte of a block is accepted, so they are valid with blk_done.
- R10: While out_valid is high and out_ready low, out_data and out_valid hold. Under any out_ready pattern the output bytes equal those produced with out_ready held high.
- R11: After reset out_valid, blk_done, header_err and in_csum_err are 0 and in_ready is 1.
- R12: mode_dig is sampled when input byte 0x00 is accepted. Changes later in the block do not affect its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dig | input | 1 | 1: present a digital-input sink, 0: analog-input sink |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Patched output byte |
| blk_done | output | 1 | Current output byte is the last of the block |
| header_err | output | 1 | Fixed header mismatch in the last block |
| in_csum_err | output | 1 | Incoming checksum wrong in the last block |

## Verification
Assertions check on every cycle that a stalled output byte holds, that blk_done appears once and is followed by readiness for a new block, that the two error flags move only on a block's final input byte, and that a header mismatch stays latched for the rest of the block. The byte values themselves can only be shown by the bench's scenarios. These values are the input-type bit and extension count per mode, the descriptor swap at, below and above the pixel clock limit and across several slots, the regenerated checksum, mode sampling at block start, and equality of the output under random back-pressure.

// File: rtl/edid_rw_pkg.sv
package edid_rw_pkg;

    localparam int BLK_LEN  = 128;
    localparam int IDX_W    = $clog2(BLK_LEN);
    localparam int HDR_LEN  = 8;
    localparam int SLOT_W   = 5;

    localparam logic [IDX_W-1:0] IDX_INTYPE = 7'h14;
    localparam logic [IDX_W-1:0] IDX_EXTCNT = 7'h7E;
    localparam logic [IDX_W-1:0] IDX_LAST   = 7'h7F;

    // Fixed header: zero at both ends, all ones in between.
    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] i);
        return (i == '0 || i == 7'(HDR_LEN - 1)) ? 8'h00 : 8'hFF;
    endfunction

    // Safe 640x480p60 descriptor, 25.18 MHz pixel clock.
    function automatic logic [7:0] safe_desc_byte(input logic [SLOT_W-1:0] off);
        logic [7:0] b;
        case (off)
            5'd0:    b = 8'hD6;
            5'd1:    b = 8'h09;
            5'd2:    b = 8'h80;
            5'd3:    b = 8'hA0;
            5'd4:    b = 8'h20;
            5'd5:    b = 8'hE0;
            5'd6:    b = 8'h2D;
            5'd7:    b = 8'h10;
            5'd8:    b = 8'h10;
            5'd9:    b = 8'h60;
            5'd10:   b = 8'hA2;
            5'd17:   b = 8'h18;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hold_vld;
        logic [7:0]       hold_byte;
        logic             mode;
        logic             repl;
        logic             flush;
        logic             out_vld;
        logic [7:0]       out_byte;
        logic             out_last;
        logic [7:0]       osum;
        logic             hdr_err;
        logic             csum_err;
    } rw_state_t;

endpackage

// File: rtl/edid_integrity.sv
module edid_integrity
    import edid_rw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic             hdr_bad,
    output logic [7:0]       sum
);

    typedef struct packed {
        logic       bad;
        logic [7:0] sum;
    } chk_t;

    chk_t chk_d, chk_q;

    always_comb begin
        chk_d = chk_q;
        if (acc) begin
            if (idx == '0) begin
                chk_d.bad = (din != hdr_byte(idx));
                chk_d.sum = din;
            end else begin
                if (idx < 7'(HDR_LEN) && din != hdr_byte(idx))
                    chk_d.bad = 1'b1;
                chk_d.sum = chk_q.sum + din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign hdr_bad = chk_q.bad;
    assign sum     = chk_q.sum;

    AST_HDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_bad && acc && idx != '0) |=> hdr_bad); // R7

endmodule

// File: rtl/edid_patch.sv
module edid_patch
    import edid_rw_pkg::*;
#(
    parameter int DESC_BASE = 'h36,
    parameter int DESC_LEN  = 18,
    parameter int DESC_CNT  = 4,
    parameter int MAX_PCLK  = 16500
) (
    input  logic             mode_dig,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       cur,
    input  logic [7:0]       nxt,
    input  logic             repl,
    output logic [7:0]       pat,
    output logic             slot_first,
    output logic             slot_over
);

    logic [DESC_CNT-1:0] in_slot;
    logic [SLOT_W-1:0]   offs [DESC_CNT];

    for (genvar k = 0; k < DESC_CNT; k++) begin : g_slot
        localparam logic [IDX_W-1:0] LO = 7'(DESC_BASE + k * DESC_LEN);
        localparam logic [IDX_W-1:0] HI = 7'(DESC_BASE + (k + 1) * DESC_LEN);
        logic [IDX_W-1:0] rel;
        assign in_slot[k] = (idx >= LO) && (idx < HI);
        assign rel        = idx - LO;
        assign offs[k]    = rel[SLOT_W-1:0];
    end

    logic [SLOT_W-1:0] off;
    logic              any_slot;
    logic [15:0]       pclk;

    always_comb begin
        off      = '0;
        any_slot = 1'b0;
        for (int k = 0; k < DESC_CNT; k++) begin
            if (in_slot[k]) begin
                any_slot = 1'b1;
                off      = offs[k];
            end
        end
    end

    assign pclk       = {nxt, cur};
    assign slot_first = any_slot && (off == '0);
    assign slot_over  = slot_first && (pclk > 16'(MAX_PCLK));

    always_comb begin
        pat = cur;
        if (idx == IDX_INTYPE) begin
            pat = {mode_dig, cur[6:0]};
        end else if (idx == IDX_EXTCNT) begin
            pat = {7'd0, mode_dig};
        end else if (any_slot) begin
            if (slot_first) begin
                if (slot_over) pat = safe_desc_byte(off);
            end else if (repl) begin
                pat = safe_desc_byte(off);
            end
        end
    end

endmodule

// File: rtl/edid_rewriter.sv
module edid_rewriter
    import edid_rw_pkg::*;
#(
    parameter int DESC_BASE = 'h36,
    parameter int DESC_LEN  = 18,
    parameter int DESC_CNT  = 4,
    parameter int MAX_PCLK  = 16500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_dig,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       blk_done,
    output logic       header_err,
    output logic       in_csum_err
);

    rw_state_t st_d, st_q;

    logic             can_load;
    logic             acc;
    logic [IDX_W-1:0] hold_idx;
    logic [7:0]       pat_byte;
    logic             slot_first;
    logic             slot_over;
    logic             hdr_bad;
    logic [7:0]       in_sum;

    assign can_load = !st_q.out_vld || out_ready;
    assign in_ready = can_load && !st_q.flush;
    assign acc      = in_valid && in_ready;
    assign hold_idx = st_q.idx - 7'd1;

    edid_integrity u_integrity (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .idx     (st_q.idx),
        .din     (in_data),
        .hdr_bad (hdr_bad),
        .sum     (in_sum)
    );

    edid_patch #(
        .DESC_BASE (DESC_BASE),
        .DESC_LEN  (DESC_LEN),
        .DESC_CNT  (DESC_CNT),
        .MAX_PCLK  (MAX_PCLK)
    ) u_patch (
        .mode_dig   (st_q.mode),
        .idx        (hold_idx),
        .cur        (st_q.hold_byte),
        .nxt        (in_data),
        .repl       (st_q.repl),
        .pat        (pat_byte),
        .slot_first (slot_first),
        .slot_over  (slot_over)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.out_vld && out_ready) begin
            st_d.out_vld  = 1'b0;
            st_d.out_last = 1'b0;
        end
        if (acc) begin
            if (st_q.idx == '0) begin
                st_d.mode = mode_dig;
                st_d.osum = 8'd0;
                st_d.repl = 1'b0;
            end
            if (st_q.hold_vld) begin
                st_d.out_vld  = 1'b1;
                st_d.out_byte = pat_byte;
                st_d.out_last = 1'b0;
                st_d.osum     = st_q.osum + pat_byte;
                if (slot_first) st_d.repl = slot_over;
            end
            st_d.hold_byte = in_data;
            st_d.hold_vld  = 1'b1;
            st_d.idx       = st_q.idx + 7'd1;
            if (st_q.idx == IDX_LAST) begin
                st_d.hold_vld = 1'b0;
                st_d.flush    = 1'b1;
                st_d.hdr_err  = hdr_bad;
                st_d.csum_err = (in_sum + in_data) != 8'd0;
            end
        end else if (st_q.flush && can_load) begin
            st_d.out_vld  = 1'b1;
            st_d.out_byte = 8'd0 - st_q.osum;
            st_d.out_last = 1'b1;
            st_d.flush    = 1'b0;
            st_d.idx      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.out_vld;
    assign out_data    = st_q.out_byte;
    assign blk_done    = st_q.out_vld && st_q.out_last;
    assign header_err  = st_q.hdr_err;
    assign in_csum_err = st_q.csum_err;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && out_ready) |=> !blk_done); // R9

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && out_ready) |=> in_ready); // R1

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && st_q.idx == IDX_LAST) |=> ($stable(header_err) && $stable(in_csum_err))); // R9

endmodule

// File: tb/sim_edid_rewriter.sv
module sim_edid_rewriter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_dig = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'd0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       blk_done;
    logic       header_err;
    logic       in_csum_err;

    always #5 clk = ~clk;

    edid_rewriter u0 (
        .clk(clk), .rst_n(rst_n), .mode_dig(mode_dig),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .blk_done(blk_done), .header_err(header_err), .in_csum_err(in_csum_err)
    );

    typedef struct packed {
        logic        mode;
        logic [15:0] p0, p1, p2, p3;
        logic        bad_hdr;
        logic        bad_sum;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 16'd16500, 16'd0,     16'd0,     16'd0,     1'b0, 1'b0},
        '{1'b1, 16'd16501, 16'd14850, 16'd0,     16'd0,     1'b0, 1'b0},
        '{1'b0, 16'd0,     16'd0,     16'd0,     16'd30000, 1'b0, 1'b0},
        '{1'b1, 16'd25000, 16'd25000, 16'd25000, 16'd25000, 1'b0, 1'b0},
        '{1'b0, 16'd7425,  16'd0,     16'd0,     16'd0,     1'b1, 1'b0},
        '{1'b1, 16'd14850, 16'd0,     16'd0,     16'd0,     1'b0, 1'b1}
    };

    localparam logic [7:0] SAFE [18] = '{
        8'hD6, 8'h09, 8'h80, 8'hA0, 8'h20, 8'hE0, 8'h2D, 8'h10, 8'h10,
        8'h60, 8'hA2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h18
    };
    localparam int LIMIT = 16500;

    logic [7:0] src [128];
    logic [7:0] expb [128];
    logic [7:0] got [128];
    int got_n, done_cnt, done_at;
    logic got_hdr, got_cs;
    bit bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // back-pressure pattern, changed well away from the sampling point
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? lfsr[0] : 1'b1;
    end

    // output collector
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (got_n < 128) got[got_n] = out_data;
            if (blk_done) begin
                done_cnt++;
                done_at = got_n;
                got_hdr = header_err;
                got_cs  = in_csum_err;
            end
            got_n++;
        end
    end

    task automatic build(input vec_t v);
        logic [7:0] s;
        logic [15:0] p [4];
        p[0] = v.p0; p[1] = v.p1; p[2] = v.p2; p[3] = v.p3;
        for (int i = 0; i < 128; i++) src[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 8; i++) src[i] = (i == 0 || i == 7) ? 8'h00 : 8'hFF;
        src[8'h12] = 8'h01;
        src[8'h13] = 8'h03;
        src[8'h14] = v.mode ? 8'h6A : 8'hEA;
        for (int k = 0; k < 4; k++) begin
            src[8'h36 + 18 * k]     = p[k][7:0];
            src[8'h36 + 18 * k + 1] = p[k][15:8];
            if (p[k] == 16'd0) begin
                src[8'h36 + 18 * k + 2] = 8'h00;
                src[8'h36 + 18 * k + 3] = 8'hFC;
            end
        end
        src[8'h7E] = 8'h02;
        if (v.bad_hdr) src[3] = 8'h7F;
        s = 8'd0;
        for (int i = 0; i < 127; i++) s = s + src[i];
        src[127] = 8'd0 - s;
        if (v.bad_sum) src[127] = src[127] ^ 8'h01;
        for (int i = 0; i < 128; i++) expb[i] = src[i];
        expb[8'h14][7] = v.mode;
        expb[8'h7E] = {7'd0, v.mode};
        for (int k = 0; k < 4; k++)
            if (p[k] > 16'(LIMIT))
                for (int j = 0; j < 18; j++) expb[8'h36 + 18 * k + j] = SAFE[j];
        s = 8'd0;
        for (int i = 0; i < 127; i++) s = s + expb[i];
        expb[127] = 8'd0 - s;
    endtask

    task automatic stream(input logic mode, input bit flip);
        got_n = 0; done_cnt = 0; done_at = -1;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (i == 0) mode_dig = mode;
            if (flip && i == 8'h10) mode_dig = ~mode;
            in_valid = 1'b1;
            in_data  = src[i];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int t = 0; t < 3000 && got_n < 128; t++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic run_block(input vec_t v, input bit flip, input string tag);
        int bad, first;
        logic [7:0] s;
        logic [15:0] p [4];
        p[0] = v.p0; p[1] = v.p1; p[2] = v.p2; p[3] = v.p3;
        build(v);
        stream(v.mode, flip);
        chk(got_n == 128, "R1", {tag, " byte count"}, got_n, 128);
        bad = 0; first = 0;
        for (int i = 0; i < 127; i++)
            if (i != 8'h14 && i != 8'h7E && got[i] != expb[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        chk(bad == 0, "R1", {tag, " copied bytes, first bad index"}, first, -1);
        chk(got[8'h14] == expb[8'h14], flip ? "R12" : "R2", {tag, " input-type byte"},
            got[8'h14], expb[8'h14]);
        chk(got[8'h7E] == expb[8'h7E], flip ? "R12" : "R3", {tag, " extension count"},
            got[8'h7E], expb[8'h7E]);
        for (int k = 0; k < 4; k++) begin
            bad = 0;
            for (int j = 0; j < 18; j++)
                if (got[8'h36 + 18 * k + j] != expb[8'h36 + 18 * k + j]) bad++;
            chk(bad == 0, (p[k] > 16'(LIMIT)) ? "R4" : "R5", {tag, " slot bytes wrong"},
                bad, 0);
        end
        s = 8'd0;
        for (int i = 0; i < 128; i++) s = s + got[i];
        chk(s == 8'd0 && got[127] == expb[127], "R6", {tag, " checksum"},
            got[127], expb[127]);
        chk(got_hdr == v.bad_hdr, "R7", {tag, " header_err"}, got_hdr, v.bad_hdr);
        chk(got_cs == v.bad_sum, "R8", {tag, " in_csum_err"}, got_cs, v.bad_sum);
        chk(done_cnt == 1 && done_at == 127, "R9", {tag, " done position"},
            done_at, 127);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && in_ready && !blk_done && !header_err && !in_csum_err,
            "R11", "reset outputs", {out_valid, in_ready, blk_done, header_err, in_csum_err},
            5'b01000);

        // table-driven blocks, free-flowing output
        for (int v = 0; v < NVEC; v++) run_block(VECS[v], 1'b0, "table");

        // R10: same blocks under random back-pressure
        bp_en = 1'b1;
        run_block(VECS[1], 1'b0, "R10 backpressure");
        run_block(VECS[3], 1'b0, "R10 backpressure");
        bp_en = 1'b0;

        // R12: mode changes mid-block, both directions
        run_block(VECS[0], 1'b1, "R12 mode flip");
        run_block(VECS[5], 1'b1, "R12 mode flip");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule